// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps instructions that are in flight between issue and retirement in program order. Each accepted issue takes the next free slot of a circular store, and the slot index goes back to the issue stage as the rename tag for that instruction's result. Execution units finish in any order and broadcast their results on a result bus that carries a tag and a value. The buffer captures each value in the matching slot and marks it ready. Retirement is strictly in order from the oldest slot.

A retiring register operation drives a register-file write. A retiring store drives a memory write that uses the stored destination as the address. A retiring branch writes nothing. If it was mispredicted, it discards every entry still held.

A rename table records, for each architectural register, which slot will produce its next value. Lookup ports let the issue stage find out whether a source register is waiting on a slot and under which tag. A lookup also returns the slot's value once that value has been computed, even though it has not yet retired. A value broadcast in the same cycle as the lookup is passed straight through.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty (`empty_o`=1, `full_o`=0, `count_o`=0), issue is accepted (`iss_ready_o`=1) and no retirement is offered.
- R2: Each accepted issue receives `iss_tag_o` equal to the current tail slot. Tags run 0,1,...,DEPTH-1 and then wrap to 0.
- R3: `full_o` rises when DEPTH entries are held, and `iss_ready_o` is then low. An issue attempted while full changes neither the count nor the rename table.
- R4: A broadcast (`wb_valid_i`) stores `wb_value_i` into slot `wb_tag_i` and marks that slot ready.
- R5: Only the oldest entry may retire, and only once it is ready. A younger ready entry waits, so retirements leave in issue order.
- R6: At retirement, kind 2 (register op) asserts `reg_we_o`, kind 1 (store) asserts `mem_we_o` with the destination as the address, and kind 0 (branch) asserts neither. The destination and value are presented on `cmt_dest_o` and `cmt_value_o`.
- R7: A retiring branch whose value has bit 0 set is a mispredict. It raises `flush_o`, empties the buffer, clears every rename mapping and returns both pointers to slot 0. A branch with bit 0 clear retires without a flush.
- R8: A lookup of a register with a pending producer reports busy and the producer's tag. Once the producer's value has arrived, the lookup also reports ready together with that value. A register with no pending producer reports not busy.
- R9: A lookup of a tag that is being broadcast in the same cycle reports ready and returns the broadcast value.
- R10: Retiring a register op clears that register's mapping only if the mapping still names the retiring slot. A later producer of the same register stays mapped.
- R11: A broadcast and a retirement in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | Issue request |
| iss_kind_i | input | 2 | Kind: 0 branch, 1 store, 2 register op |
| iss_dest_i | input | DEST_W | Register number or memory address |
| iss_ready_o | output | 1 | A slot is free and no flush is in progress |
| iss_tag_o | output | log2(DEPTH) | Tag given to the issuing instruction |
| src_reg_i | input | NSRC*log2(NREG) | Source registers to look up |
| src_busy_o | output | NSRC | Source has a pending producer |
| src_tag_o | output | NSRC*log2(DEPTH) | Tag of that producer |
| src_ready_o | output | NSRC | Producer value is available |
| src_value_o | output | NSRC*DATA_W | Producer value |
| wb_valid_i | input | 1 | Result broadcast valid |
| wb_tag_i | input | log2(DEPTH) | Tag of the broadcast result |
| wb_value_i | input | DATA_W | Broadcast value (bit 0 = mispredict for a branch) |
| cmt_valid_o | output | 1 | Oldest entry retires at this edge |
| cmt_kind_o | output | 2 | Kind of the retiring entry |
| cmt_dest_o | output | DEST_W | Destination of the retiring entry |
| cmt_value_o | output | DATA_W | Value of the retiring entry |
| reg_we_o | output | 1 | Register-file write |
| mem_we_o | output | 1 | Memory write |
| flush_o | output | 1 | Mispredicted branch retires; all entries are discarded |
| count_o | output | log2(DEPTH+1) | Entries held |
| full_o | output | 1 | Buffer full |
| empty_o | output | 1 | Buffer empty |

## Verification
The assertions assume that a broadcast names only a slot that is currently held and not yet ready, and that each slot is broadcast once. They also assume that an issue request is not held across a flush with the expectation that it will be taken. The stimulus keeps to these assumptions: every broadcast uses a tag the bench itself received at issue, and no slot is broadcast twice. The one issue made while full is deliberately refused, and the bench checks that refusal at the ports.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        KIND_BRANCH = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_REGOP  = 2'd2
    } op_kind_e;
endpackage

// File: rtl/rob_slots.sv
module rob_slots
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int DEST_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_i,
    input  logic [1:0]                    alloc_kind_i,
    input  logic [DEST_W-1:0]             alloc_dest_i,
    input  logic                          wb_i,
    input  logic [$clog2(DEPTH)-1:0]      wb_tag_i,
    input  logic [DATA_W-1:0]             wb_value_i,
    output logic [$clog2(DEPTH)-1:0]      tail_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o,
    output logic                          retire_o,
    output logic                          flush_o,
    output logic [1:0]                    head_kind_o,
    output logic [DEST_W-1:0]             head_dest_o,
    output logic [DATA_W-1:0]             head_value_o,
    output logic [DEPTH-1:0]              ent_ready_o,
    output logic [DEPTH-1:0][DATA_W-1:0]  ent_value_o
);
    localparam int TAG_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH-1);

    typedef struct packed {
        logic [TAG_W-1:0]             head;
        logic [TAG_W-1:0]             tail;
        logic [CNT_W-1:0]             count;
        logic [DEPTH-1:0]             rdy;
        logic [DEPTH-1:0][1:0]        kind;
        logic [DEPTH-1:0][DEST_W-1:0] dst;
        logic [DEPTH-1:0][DATA_W-1:0] val;
    } slot_state_t;

    slot_state_t s_d, s_q;
    logic retire, flush;

    always_comb begin
        retire = (s_q.count != '0) && s_q.rdy[s_q.head];
        flush  = retire && (s_q.kind[s_q.head] == KIND_BRANCH) && s_q.val[s_q.head][0];
        s_d = s_q;
        if (wb_i) begin
            s_d.val[wb_tag_i] = wb_value_i;
            s_d.rdy[wb_tag_i] = 1'b1;
        end
        if (alloc_i) begin
            s_d.kind[s_q.tail] = alloc_kind_i;
            s_d.dst[s_q.tail]  = alloc_dest_i;
            s_d.val[s_q.tail]  = '0;
            s_d.rdy[s_q.tail]  = 1'b0;
            s_d.tail = (s_q.tail == LAST) ? '0 : s_q.tail + 1'b1;
        end
        if (retire) begin
            s_d.rdy[s_q.head] = 1'b0;
            s_d.head = (s_q.head == LAST) ? '0 : s_q.head + 1'b1;
        end
        s_d.count = s_q.count + CNT_W'(alloc_i) - CNT_W'(retire);
        if (flush) begin
            s_d.head  = '0;
            s_d.tail  = '0;
            s_d.count = '0;
            s_d.rdy   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tail_o       = s_q.tail;
    assign count_o      = s_q.count;
    assign retire_o     = retire;
    assign flush_o      = flush;
    assign head_kind_o  = s_q.kind[s_q.head];
    assign head_dest_o  = s_q.dst[s_q.head];
    assign head_value_o = s_q.val[s_q.head];
    assign ent_ready_o  = s_q.rdy;
    assign ent_value_o  = s_q.val;

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CNT_W'(DEPTH));
    assert_count_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !retire) |=> (s_q.count == $past(s_q.count) + 1'b1));
    assert_wb_sets_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_i && !flush) |=> s_q.rdy[$past(wb_tag_i)]);
    assert_head_in_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !flush) |=> (s_q.head == (($past(s_q.head) == LAST) ? '0 : $past(s_q.head) + 1'b1)));
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.count == '0 && s_q.head == '0 && s_q.tail == '0));
endmodule

// File: rtl/rob_rename_map.sv
module rob_rename_map #(
    parameter int NREG  = 16,
    parameter int TAG_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_i,
    input  logic [$clog2(NREG)-1:0]        set_reg_i,
    input  logic [TAG_W-1:0]               set_tag_i,
    input  logic                           clr_i,
    input  logic [$clog2(NREG)-1:0]        clr_reg_i,
    input  logic [TAG_W-1:0]               clr_tag_i,
    input  logic                           flush_i,
    output logic [NREG-1:0]                map_valid_o,
    output logic [NREG-1:0][TAG_W-1:0]     map_tag_o
);
    typedef struct packed {
        logic [NREG-1:0]            vld;
        logic [NREG-1:0][TAG_W-1:0] tag;
    } map_state_t;

    map_state_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (clr_i && m_q.vld[clr_reg_i] && (m_q.tag[clr_reg_i] == clr_tag_i)) begin
            m_d.vld[clr_reg_i] = 1'b0;
        end
        if (set_i) begin
            m_d.vld[set_reg_i] = 1'b1;
            m_d.tag[set_reg_i] = set_tag_i;
        end
        if (flush_i) begin
            m_d.vld = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign map_valid_o = m_q.vld;
    assign map_tag_o   = m_q.tag;

    assert_flush_unmaps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (m_q.vld == '0));
    assert_newest_producer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !flush_i) |=> (m_q.vld[$past(set_reg_i)] && m_q.tag[$past(set_reg_i)] == $past(set_tag_i)));
endmodule

// File: rtl/spec_rob.sv
module spec_rob
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int DEST_W = 16,
    parameter int NREG   = 16,
    parameter int NSRC   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               iss_valid_i,
    input  logic [1:0]                         iss_kind_i,
    input  logic [DEST_W-1:0]                  iss_dest_i,
    output logic                               iss_ready_o,
    output logic [$clog2(DEPTH)-1:0]           iss_tag_o,
    input  logic [NSRC*$clog2(NREG)-1:0]       src_reg_i,
    output logic [NSRC-1:0]                    src_busy_o,
    output logic [NSRC*$clog2(DEPTH)-1:0]      src_tag_o,
    output logic [NSRC-1:0]                    src_ready_o,
    output logic [NSRC*DATA_W-1:0]             src_value_o,
    input  logic                               wb_valid_i,
    input  logic [$clog2(DEPTH)-1:0]           wb_tag_i,
    input  logic [DATA_W-1:0]                  wb_value_i,
    output logic                               cmt_valid_o,
    output logic [1:0]                         cmt_kind_o,
    output logic [DEST_W-1:0]                  cmt_dest_o,
    output logic [DATA_W-1:0]                  cmt_value_o,
    output logic                               reg_we_o,
    output logic                               mem_we_o,
    output logic                               flush_o,
    output logic [$clog2(DEPTH+1)-1:0]         count_o,
    output logic                               full_o,
    output logic                               empty_o
);
    localparam int TAG_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int REG_W = $clog2(NREG);

    logic [TAG_W-1:0]             tail, head_tag;
    logic [CNT_W-1:0]             count;
    logic                         retire, flush, alloc;
    logic [1:0]                   head_kind;
    logic [DEST_W-1:0]            head_dest;
    logic [DATA_W-1:0]            head_value;
    logic [DEPTH-1:0]             ent_ready;
    logic [DEPTH-1:0][DATA_W-1:0] ent_value;
    logic [NREG-1:0]              map_valid;
    logic [NREG-1:0][TAG_W-1:0]   map_tag;

    assign full_o      = (count == CNT_W'(DEPTH));
    assign empty_o     = (count == '0);
    assign iss_ready_o = !full_o && !flush;
    assign alloc       = iss_valid_i && iss_ready_o;
    assign iss_tag_o   = tail;
    assign head_tag    = TAG_W'((32'(tail) + DEPTH - 32'(count)) % DEPTH);

    rob_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .alloc_i(alloc), .alloc_kind_i(iss_kind_i), .alloc_dest_i(iss_dest_i),
        .wb_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_value_i(wb_value_i),
        .tail_o(tail), .count_o(count), .retire_o(retire), .flush_o(flush),
        .head_kind_o(head_kind), .head_dest_o(head_dest), .head_value_o(head_value),
        .ent_ready_o(ent_ready), .ent_value_o(ent_value)
    );

    rob_rename_map #(.NREG(NREG), .TAG_W(TAG_W)) u_map (
        .clk(clk), .rst_n(rst_n),
        .set_i(alloc && iss_kind_i == KIND_REGOP),
        .set_reg_i(iss_dest_i[REG_W-1:0]), .set_tag_i(tail),
        .clr_i(retire && head_kind == KIND_REGOP),
        .clr_reg_i(head_dest[REG_W-1:0]), .clr_tag_i(head_tag),
        .flush_i(flush),
        .map_valid_o(map_valid), .map_tag_o(map_tag)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [REG_W-1:0] r;
        logic [TAG_W-1:0] t;
        logic             byp;
        assign r   = src_reg_i[i*REG_W +: REG_W];
        assign t   = map_tag[r];
        assign byp = wb_valid_i && (wb_tag_i == t);
        assign src_busy_o[i]                = map_valid[r];
        assign src_tag_o[i*TAG_W +: TAG_W]  = t;
        assign src_ready_o[i]               = map_valid[r] && (ent_ready[t] || byp);
        assign src_value_o[i*DATA_W +: DATA_W] =
            !map_valid[r] ? '0 : (byp ? wb_value_i : ent_value[t]);
    end

    assign cmt_valid_o = retire;
    assign cmt_kind_o  = head_kind;
    assign cmt_dest_o  = head_dest;
    assign cmt_value_o = head_value;
    assign reg_we_o    = retire && head_kind == KIND_REGOP;
    assign mem_we_o    = retire && head_kind == KIND_STORE;
    assign flush_o     = flush;
    assign count_o     = count;

    assert_commit_needs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid_o |-> !empty_o);
    assert_full_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !retire) |=> (count == $past(count)));
    assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we_o, mem_we_o, flush_o}));
endmodule

// File: tb/spec_rob_test.sv
`timescale 1ns/1ps
module spec_rob_test;
    localparam int DEPTH = 8, DATA_W = 32, DEST_W = 16, NREG = 16, NSRC = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic iss_valid, iss_ready;
    logic [1:0] iss_kind;
    logic [DEST_W-1:0] iss_dest;
    logic [2:0] iss_tag;
    logic [7:0] src_reg;
    logic [1:0] src_busy, src_ready;
    logic [5:0] src_tag;
    logic [63:0] src_value;
    logic wb_valid;
    logic [2:0] wb_tag;
    logic [31:0] wb_value;
    logic cmt_valid, reg_we, mem_we, flush, full, empty;
    logic [1:0] cmt_kind;
    logic [15:0] cmt_dest;
    logic [31:0] cmt_value;
    logic [3:0] count;

    spec_rob #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .NREG(NREG), .NSRC(NSRC)) uut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid_i(iss_valid), .iss_kind_i(iss_kind), .iss_dest_i(iss_dest),
        .iss_ready_o(iss_ready), .iss_tag_o(iss_tag),
        .src_reg_i(src_reg), .src_busy_o(src_busy), .src_tag_o(src_tag),
        .src_ready_o(src_ready), .src_value_o(src_value),
        .wb_valid_i(wb_valid), .wb_tag_i(wb_tag), .wb_value_i(wb_value),
        .cmt_valid_o(cmt_valid), .cmt_kind_o(cmt_kind), .cmt_dest_o(cmt_dest),
        .cmt_value_o(cmt_value), .reg_we_o(reg_we), .mem_we_o(mem_we), .flush_o(flush),
        .count_o(count), .full_o(full), .empty_o(empty)
    );

    typedef struct {
        logic [1:0]  kind;
        logic [15:0] dest;
        logic [31:0] value;
        logic        flush;
    } exp_t;
    exp_t expq[$];
    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every retirement
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (rst_n && cmt_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R5 unexpected retirement", {cmt_kind, cmt_dest}, 0);
            end else begin
                e = expq.pop_front();
                chk(cmt_kind == e.kind && cmt_dest == e.dest && cmt_value == e.value,
                    "R5 retirement order", {cmt_kind, cmt_dest, cmt_value}, {e.kind, e.dest, e.value});
                chk(reg_we == (e.kind == 2'd2) && mem_we == (e.kind == 2'd1),
                    "R6 write enables", {reg_we, mem_we}, {e.kind == 2'd2, e.kind == 2'd1});
                chk(flush == e.flush, "R7 flush on retirement", flush, e.flush);
            end
        end
    end

    task automatic do_issue(input logic [1:0] k, input logic [15:0] d, input logic [31:0] v,
                            input logic [2:0] exp_tag, input bit push, input bit fl);
        exp_t e;
        iss_valid = 1'b1; iss_kind = k; iss_dest = d;
        #1;
        chk(iss_ready && iss_tag == exp_tag, "R2 issue tag", {iss_ready, iss_tag}, {1'b1, exp_tag});
        if (push) begin
            e.kind = k; e.dest = d; e.value = v; e.flush = fl;
            expq.push_back(e);
        end
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic do_wb(input logic [2:0] t, input logic [31:0] v);
        wb_valid = 1'b1; wb_tag = t; wb_value = v;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic look(input logic [3:0] r, input bit busy, input logic [2:0] t,
                        input bit rdy, input logic [31:0] v, input string req);
        src_reg[3:0] = r;
        #1;
        chk(src_busy[0] == busy, req, src_busy[0], busy);
        if (busy) begin
            chk(src_tag[2:0] == t && src_ready[0] == rdy, req, {src_tag[2:0], src_ready[0]}, {t, rdy});
            if (rdy) chk(src_value[31:0] == v, req, src_value[31:0], v);
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #80000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; iss_valid = 0; iss_kind = 0; iss_dest = 0;
        src_reg = 0; wb_valid = 0; wb_tag = 0; wb_value = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(empty && !full && count == 0 && iss_ready && !cmt_valid, "R1 reset state",
            {empty, full, count, iss_ready, cmt_valid}, {1'b1, 1'b0, 4'd0, 1'b1, 1'b0});
        @(negedge clk);

        // R2/R6: a register op, a store and another register op
        do_issue(2'd2, 16'd3,      32'h1111_0003, 3'd0, 1, 0);
        do_issue(2'd1, 16'h0040,   32'hCAFE_0001, 3'd1, 1, 0);
        do_issue(2'd2, 16'd5,      32'h0000_5555, 3'd2, 1, 0);
        look(4'd3, 1, 3'd0, 0, 0, "R8 pending producer");

        // R4/R5: younger result arrives first and must wait
        do_wb(3'd2, 32'h0000_5555);
        src_reg[3:0] = 4'd5;
        #1;
        chk(!cmt_valid, "R5 head not ready blocks retirement", cmt_valid, 0);
        chk(src_ready[0] && src_value[31:0] == 32'h5555, "R4 broadcast captured",
            {src_ready[0], src_value[31:0]}, {1'b1, 32'h5555});
        @(negedge clk);

        // R9: bypass of a same-cycle broadcast
        wb_valid = 1'b1; wb_tag = 3'd0; wb_value = 32'h1111_0003; src_reg[3:0] = 4'd3;
        #1;
        chk(src_ready[0] && src_value[31:0] == 32'h1111_0003, "R9 same-cycle bypass",
            {src_ready[0], src_value[31:0]}, {1'b1, 32'h1111_0003});
        @(negedge clk);
        wb_valid = 1'b0;
        // R11: broadcast into slot 1 while slot 0 retires
        do_wb(3'd1, 32'hCAFE_0001);
        repeat (3) @(negedge clk);
        #1;
        chk(empty && count == 0, "R11 both retired after overlap", count, 0);
        @(negedge clk);
        look(4'd3, 0, 0, 0, 0, "R10 mapping cleared at retirement");

        // R10: two producers of register 7
        do_issue(2'd2, 16'd7, 32'h7777, 3'd3, 1, 0);
        do_issue(2'd2, 16'd7, 32'h8888, 3'd4, 1, 0);
        do_wb(3'd3, 32'h7777);
        @(negedge clk);
        look(4'd7, 1, 3'd4, 0, 0, "R10 newer producer kept");
        do_wb(3'd4, 32'h8888);
        repeat (2) @(negedge clk);
        look(4'd7, 0, 0, 0, 0, "R10 mapping cleared by last producer");

        // R3: fill with a branch at the head, then register ops
        do_issue(2'd0, 16'd0, 32'h1, 3'd5, 1, 1);
        for (int i = 1; i < 8; i++) do_issue(2'd2, 16'(i), 0, 3'((5 + i) % 8), 0, 0);
        #1;
        chk(full && !iss_ready && count == 8, "R3 full", {full, iss_ready, count}, {1'b1, 1'b0, 4'd8});
        @(negedge clk);
        iss_valid = 1'b1; iss_kind = 2'd2; iss_dest = 16'd9;
        @(negedge clk);
        iss_valid = 1'b0;
        look(4'd9, 0, 0, 0, 0, "R3 refused issue leaves map");
        #1;
        chk(count == 8, "R3 refused issue leaves count", count, 8);
        @(negedge clk);

        // R7: mispredicted branch retires and flushes
        do_wb(3'd6, 32'h66);
        do_wb(3'd5, 32'h1);
        @(negedge clk);
        #1;
        chk(empty && count == 0, "R7 flushed empty", count, 0);
        @(negedge clk);
        look(4'd1, 0, 0, 0, 0, "R7 mappings cleared");
        do_issue(2'd0, 16'd0, 32'h0, 3'd0, 1, 0);
        do_wb(3'd0, 32'h0);
        repeat (2) @(negedge clk);
        do_issue(2'd2, 16'd2, 32'h2222, 3'd1, 1, 0);
        do_wb(3'd1, 32'h2222);
        repeat (2) @(negedge clk);
        #1;
        chk(expq.size() == 0 && empty, "R5 all expected retirements seen", expq.size(), 0);
        summary();
        $finish;
    end
endmodule